// File: doc/BRIEF.md
# Serial Packet to Bus Bridge

This block sits between a UART byte receiver/transmitter pair and a parallel register bus with a 16-bit address and a 32-bit data path. It collects fixed 7-byte command packets from the receive byte stream and decodes the first byte into an operation code, a direction flag and a 4-bit module number. When the packet is meant for this module, the block performs at most one 32-bit bus access and then returns a fixed 5-byte reply on the transmit byte stream.

Both byte streams use valid/ready. On the receive side a byte moves on a clock edge where `rx_valid` and `rx_ready` are both high. The block drops `rx_ready` from the moment a full packet is held until that packet has been dropped or fully answered. On the transmit side `tx_valid` stays high and `tx_data` stays unchanged until the transmitter raises `tx_ready`, so the transmitter can stall the reply for any number of cycles. Several modules can share one controller line, because only the module whose number matches answers. The bus side uses a request/acknowledge master with a bounded wait.

Top module: `ser_bus_bridge`

## Requirements
- R1: A command packet is 7 bytes taken in this order: command byte, address bits 15:8, address bits 7:0, then data bits 31:24, 23:16, 15:8, 7:0. A bus access uses that address (bits 15:2) and that data.
- R2: The reply is 5 bytes. Byte one is the received command byte with bit 4 set to 1 and bits 7:5 and 3:0 unchanged. Bytes two to five are the reply word, most significant byte first.
- R3: While `bus_req` is high, bits 1:0 of `bus_addr` are 0.
- R4: A packet is served only when command bits 3:0 equal the `MODULE_ID` parameter. Any other packet produces no reply byte and no bus request.
- R5: A packet whose command bit 4 is 1 is ignored completely: no reply and no bus request, even when its module number matches.
- R6: Opcode 000 (command bits 7:5) replies with 0xA110A110 and does not touch the bus.
- R7: Opcode 001 performs a bus write (`bus_we`=1) of the packet data to the packet address. After the acknowledge, the reply echoes the written word.
- R8: Opcodes 010, 011 and 100 each perform a bus read (`bus_we`=0). The reply carries the `bus_rdata` value present in the acknowledge cycle.
- R9: Opcodes 101 and 110 reply with 0xDEADD0D0, and opcode 111 replies with 0xEEEEAAAA. None of them touches the bus.
- R10: `bus_req` with its address, write enable and write data stays unchanged until `bus_ack`. If no acknowledge arrives, `bus_req` is high for exactly `ACK_TIMEOUT` cycles, then drops, and the reply word is 0xDEADD0D0.
- R11: If more than `GAP_TIMEOUT` cycles pass after an accepted byte of a partial packet without another byte, the partial packet is discarded and the next byte is taken as a command byte. A shorter gap keeps the packet.
- R12: After reset `rx_ready` is 1, and `tx_valid` and `bus_req` are 0. While a reply byte waits, `tx_valid` and `tx_data` hold until `tx_ready`. `rx_ready` stays 0 from the start of a served packet until its fifth reply byte has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte is present |
| rx_ready | output | 1 | Block can take a received byte |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Reply byte is present |
| tx_ready | input | 1 | Transmitter takes the reply byte |
| tx_data | output | 8 | Reply byte |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | 16 | Byte address, bits 1:0 zero |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Slave completes the access |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |

## Verification
The bench sweeps every opcode against every module number, with the direction flag both clear and set, and uses unaligned addresses and varied acknowledge latencies. A decoder that compared the wrong nibble, or that ignored the flag, would answer a foreign packet or a reply from another module, and this shows up as unexpected reply bytes or bus requests. A partial packet is stalled both just under and well past the byte-gap limit. A parser without the gap timeout would then fold the following test packet into a write, and one with the limit set too tight would drop a slow packet. A slave that never acknowledges checks that the request lasts exactly the configured number of cycles and that the fault word comes back. Reply bytes are taken under stalls to catch data that moves early, and the receive side is watched so that a new command cannot slip in during a reply.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  localparam int CMD_BYTES      = 7;
  localparam int RPL_BYTES      = 5;
  localparam int FLAG_BIT       = 4;

  localparam logic [31:0] WORD_HELLO = 32'hA110A110;
  localparam logic [31:0] WORD_FAULT = 32'hDEADD0D0;
  localparam logic [31:0] WORD_TRIG  = 32'hEEEEAAAA;

  typedef enum logic [2:0] {
    OP_PING   = 3'd0,
    OP_WR     = 3'd1,
    OP_RD     = 3'd2,
    OP_RD_ALT = 3'd3,
    OP_STAT   = 3'd4,
    OP_RSV_A  = 3'd5,
    OP_RSV_B  = 3'd6,
    OP_TRIG   = 3'd7
  } opcode_e;

  // packed in arrival order, first byte most significant
  typedef struct packed {
    logic [7:0]  cmd;
    logic [15:0] addr;
    logic [31:0] data;
  } frame_t;

endpackage

// File: rtl/bridge_frame_rx.sv
module bridge_frame_rx
  import bridge_pkg::*;
#(
  parameter int GAP_TIMEOUT = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic [7:0] rx_data,
  input  logic       take,
  output logic       frame_valid,
  output frame_t     frame
);

  localparam int GW = $clog2(GAP_TIMEOUT + 1);
  localparam int IW = $clog2(CMD_BYTES);

  logic [$bits(frame_t)-1:0] shreg;
  logic [IW-1:0]             idx;
  logic [GW-1:0]             gap;
  logic                      full;

  assign rx_ready    = enable && !full;
  assign frame_valid = full;
  assign frame       = frame_t'(shreg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      idx   <= '0;
      gap   <= '0;
      full  <= 1'b0;
    end else begin
      if (take) full <= 1'b0;
      if (rx_valid && rx_ready) begin
        shreg <= {shreg[$bits(frame_t)-9:0], rx_data};
        gap   <= '0;
        if (idx == IW'(CMD_BYTES - 1)) begin
          idx  <= '0;
          full <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end else if (idx != '0) begin
        if (gap == GW'(GAP_TIMEOUT - 1)) begin
          idx <= '0;
          gap <= '0;
        end else begin
          gap <= gap + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/bridge_bus_master.sv
module bridge_bus_master #(
  parameter int ACK_TIMEOUT = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        start_we,
  input  logic [15:0] start_addr,
  input  logic [31:0] start_wdata,
  output logic        bus_req,
  output logic        bus_we,
  output logic [15:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic        bus_ack,
  input  logic [31:0] bus_rdata,
  output logic        done,
  output logic        timed_out,
  output logic [31:0] rdata
);

  localparam int CW = $clog2(ACK_TIMEOUT + 1);

  logic          busy;
  logic [CW-1:0] cnt;

  assign bus_req = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      done      <= 1'b0;
      timed_out <= 1'b0;
      rdata     <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy      <= 1'b1;
        cnt       <= '0;
        bus_we    <= start_we;
        bus_addr  <= start_addr & 16'hFFFC;
        bus_wdata <= start_wdata;
      end else if (busy) begin
        if (bus_ack) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          timed_out <= 1'b0;
          rdata     <= bus_rdata;
        end else if (cnt == CW'(ACK_TIMEOUT - 1)) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          timed_out <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/bridge_reply_tx.sv
module bridge_reply_tx
  import bridge_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [7:0]  load_cmd,
  input  logic [31:0] load_word,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        done
);

  localparam int SW = 8 * RPL_BYTES;
  localparam int LW = $clog2(RPL_BYTES + 1);

  logic [SW-1:0] shreg;
  logic [LW-1:0] left;

  assign tx_valid = (left != '0);
  assign tx_data  = shreg[SW-1 -: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      left  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        shreg <= {load_cmd | 8'(1 << FLAG_BIT), load_word};
        left  <= LW'(RPL_BYTES);
      end else if (tx_valid && tx_ready) begin
        shreg <= shreg << 8;
        left  <= left - 1'b1;
        if (left == LW'(1)) done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ser_bus_bridge.sv
module ser_bus_bridge
  import bridge_pkg::*;
#(
  parameter int MODULE_ID   = 8,
  parameter int ACK_TIMEOUT = 16,
  parameter int GAP_TIMEOUT = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        bus_req,
  output logic        bus_we,
  output logic [15:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic        bus_ack,
  input  logic [31:0] bus_rdata
);

  localparam logic [3:0] MY_ID = 4'(MODULE_ID);

  typedef enum logic [1:0] {ST_IDLE, ST_BUS, ST_REPLY} state_e;

  state_e      st;
  frame_t      frame;
  logic        frame_valid, take;
  opcode_e     op;
  logic        for_us, needs_bus;
  logic [31:0] fixed_word;

  logic        bm_start, bm_done, bm_timeout;
  logic [31:0] bm_rdata;
  logic        tx_load, tx_done;
  logic [7:0]  tx_load_cmd;
  logic [31:0] tx_load_word;

  logic [7:0]  cmd_q;
  logic [31:0] wdata_q;
  logic        we_q;

  bridge_frame_rx #(.GAP_TIMEOUT(GAP_TIMEOUT)) u_rx (
    .clk(clk), .rst_n(rst_n), .enable(st == ST_IDLE),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .take(take), .frame_valid(frame_valid), .frame(frame)
  );

  assign op        = opcode_e'(frame.cmd[7:5]);
  assign for_us    = !frame.cmd[FLAG_BIT] && (frame.cmd[3:0] == MY_ID);
  assign needs_bus = (op == OP_WR) || (op == OP_RD) || (op == OP_RD_ALT) || (op == OP_STAT);

  always_comb begin
    case (op)
      OP_PING: fixed_word = WORD_HELLO;
      OP_TRIG: fixed_word = WORD_TRIG;
      default: fixed_word = WORD_FAULT;
    endcase
  end

  assign take     = (st == ST_IDLE) && frame_valid;
  assign bm_start = take && for_us && needs_bus;
  assign tx_load  = (take && for_us && !needs_bus) || ((st == ST_BUS) && bm_done);

  always_comb begin
    if (st == ST_IDLE) begin
      tx_load_cmd  = frame.cmd;
      tx_load_word = fixed_word;
    end else begin
      tx_load_cmd  = cmd_q;
      tx_load_word = bm_timeout ? WORD_FAULT : (we_q ? wdata_q : bm_rdata);
    end
  end

  bridge_bus_master #(.ACK_TIMEOUT(ACK_TIMEOUT)) u_bm (
    .clk(clk), .rst_n(rst_n), .start(bm_start), .start_we(op == OP_WR),
    .start_addr(frame.addr), .start_wdata(frame.data),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .done(bm_done), .timed_out(bm_timeout), .rdata(bm_rdata)
  );

  bridge_reply_tx u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .load_cmd(tx_load_cmd),
    .load_word(tx_load_word), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .done(tx_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cmd_q   <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (take && for_us) begin
          cmd_q   <= frame.cmd;
          wdata_q <= frame.data;
          we_q    <= (op == OP_WR);
          st      <= needs_bus ? ST_BUS : ST_REPLY;
        end
        ST_BUS:   if (bm_done) st <= ST_REPLY;
        ST_REPLY: if (tx_done) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ser_bus_bridge_checker.sv
module ser_bus_bridge_checker #(
  parameter int ACK_TIMEOUT = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_ready,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        bus_req,
  input logic        bus_we,
  input logic [15:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic        bus_ack
);

  int unsigned req_cnt;
  int unsigned beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_cnt <= 0;
      beat    <= 0;
    end else begin
      req_cnt <= bus_req ? req_cnt + 1 : 0;
      if (tx_valid && tx_ready) beat <= (beat == 4) ? 0 : beat + 1;
    end
  end

  p_addr_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_addr[1:0] == 2'b00);

  p_bus_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (!bus_req ||
      ($stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata))));

  p_ack_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> req_cnt < ACK_TIMEOUT);

  p_tx_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_rx_blocked_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid || bus_req) |-> !rx_ready);

  p_reply_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && beat == 0) |-> tx_data[4]);

endmodule

bind ser_bus_bridge ser_bus_bridge_checker #(.ACK_TIMEOUT(ACK_TIMEOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack)
);

// File: tb/ser_bus_bridge_tb_top.sv
module ser_bus_bridge_tb_top;

  localparam int ID  = 5;
  localparam int ACK = 12;
  localparam int GAP = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_ready;
  logic [7:0]  rx_data = '0;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        bus_req, bus_we, bus_ack;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  always #2.5 clk = ~clk;

  ser_bus_bridge #(.MODULE_ID(ID), .ACK_TIMEOUT(ACK), .GAP_TIMEOUT(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  // slave model
  logic [31:0] mem [16];
  logic        ack_en = 1'b1;
  int          ack_delay = 0;
  int          dcnt, acc_cnt;
  logic [15:0] last_addr;
  logic        last_we;
  logic [31:0] last_wdata;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= (32'(i) * 32'h01030507) ^ 32'h5A5A0000;
      bus_ack <= 1'b0; bus_rdata <= '0; dcnt <= 0; acc_cnt <= 0;
      last_addr <= '0; last_we <= 1'b0; last_wdata <= '0;
    end else begin
      bus_ack <= 1'b0;
      if (bus_req && !bus_ack && ack_en) begin
        if (dcnt >= ack_delay) begin
          bus_ack    <= 1'b1;
          dcnt       <= 0;
          acc_cnt    <= acc_cnt + 1;
          last_addr  <= bus_addr;
          last_we    <= bus_we;
          last_wdata <= bus_wdata;
          bus_rdata  <= mem[bus_addr[5:2]];
          if (bus_we) mem[bus_addr[5:2]] <= bus_wdata;
        end else dcnt <= dcnt + 1;
      end else if (!bus_req) dcnt <= 0;
    end
  end

  int txv_cyc = 0, req_cyc = 0;
  always @(negedge clk) if (rst_n) begin
    if (tx_valid) txv_cyc++;
    if (bus_req)  req_cyc++;
  end

  int nchk = 0, nfail = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_pkt(input logic [7:0] c, input logic [15:0] a, input logic [31:0] d);
    logic [55:0] f;
    f = {c, a, d};
    for (int i = 0; i < 7; i++) send_byte(f[55 - 8*i -: 8]);
  endtask

  task automatic get_reply(output logic [39:0] r);
    r = '0;
    for (int i = 0; i < 5; i++) begin
      int w;
      w = 0;
      while (!tx_valid && w < 300) begin @(negedge clk); w++; end
      if (i == 0) check(rx_ready == 1'b0, "R12 rx blocked during reply", 32'(rx_ready), 0);
      repeat (i % 3) @(negedge clk);
      r = {r[31:0], tx_data};
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
    end
  endtask

  function automatic string op_tag(input int op);
    case (op)
      0: return "R6 test word";
      1: return "R7 write echo";
      2, 3, 4: return "R8 read data";
      default: return "R9 fixed word";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    logic [39:0] r;
    logic [7:0]  c;
    logic [15:0] a;
    logic [31:0] d, exp;
    int a0, t0, q0;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rx_ready && !tx_valid && !bus_req, "R12 reset state",
          {29'd0, rx_ready, tx_valid, bus_req}, 32'h4);

    // sweep: opcode x destination x flag
    for (int op = 0; op < 8; op++)
      for (int dst = 0; dst < 16; dst++)
        for (int fl = 0; fl < 2; fl++) begin
          bit us, bus;
          c = {3'(op), 1'(fl), 4'(dst)};
          a = 16'(op * 16'h1357 + dst * 16'h0244 + fl + 1) | 16'h0001;
          d = {8'(op), 8'(dst), 16'hC3A5 ^ 16'(fl * 77)};
          ack_delay = (op + dst) % 4;
          us  = (fl == 0) && (dst == ID);
          bus = (op >= 1 && op <= 4);
          case (op)
            0: exp = 32'hA110A110;
            1: exp = d;
            2, 3, 4: exp = mem[a[5:2]];
            7: exp = 32'hEEEEAAAA;
            default: exp = 32'hDEADD0D0;
          endcase
          a0 = acc_cnt;
          send_pkt(c, a, d);
          if (us) begin
            get_reply(r);
            check(r[39:32] == (c | 8'h10), "R2 reply command byte", 32'(r[39:32]), 32'(c | 8'h10));
            check(r[31:0] == exp, op_tag(op), r[31:0], exp);
            check(acc_cnt - a0 == (bus ? 1 : 0), "R6 R9 bus use by opcode", 32'(acc_cnt - a0), bus ? 1 : 0);
            if (bus) begin
              check(last_addr[15:2] == a[15:2], "R1 address bytes", 32'(last_addr), 32'(a));
              check(last_addr[1:0] == 2'b00, "R3 low address bits", 32'(last_addr[1:0]), 0);
              check(last_we == (op == 1), "R7 R8 write enable", 32'(last_we), 32'(op == 1));
              if (op == 1) check(last_wdata == d, "R1 R7 write data order", last_wdata, d);
            end
          end else begin
            t0 = txv_cyc; q0 = req_cyc;
            repeat (25) @(negedge clk);
            check(txv_cyc == t0 && req_cyc == q0, fl ? "R5 flagged packet ignored" : "R4 foreign module ignored",
                  32'(txv_cyc - t0 + req_cyc - q0), 0);
          end
        end

    // R11: long gap discards partial write packet
    a0 = acc_cnt;
    send_byte({3'd1, 1'b0, 4'(ID)}); send_byte(8'h12); send_byte(8'h34);
    repeat (GAP + 5) @(negedge clk);
    send_pkt({3'd0, 1'b0, 4'(ID)}, 16'h0040, 32'h0);
    get_reply(r);
    check(r == {8'h10 | 8'(ID), 32'hA110A110}, "R11 partial discarded after gap", r[31:0], 32'hA110A110);
    check(acc_cnt == a0, "R11 no bus access from discarded bytes", 32'(acc_cnt - a0), 0);

    // R11: short gap keeps packet
    send_byte({3'd7, 1'b0, 4'(ID)}); send_byte(8'h00); send_byte(8'h08);
    repeat (GAP - 6) @(negedge clk);
    for (int i = 0; i < 4; i++) send_byte(8'h11);
    get_reply(r);
    check(r == {8'hF0 | 8'(ID), 32'hEEEEAAAA}, "R11 short gap keeps packet", r[31:0], 32'hEEEEAAAA);

    // R10: slow acknowledge inside window
    ack_delay = 8;
    exp = mem[4'hB];
    send_pkt({3'd2, 1'b0, 4'(ID)}, 16'h002E, 32'h0);
    get_reply(r);
    check(r[31:0] == exp, "R10 slow ack read", r[31:0], exp);

    // R10: no acknowledge at all, read then write
    ack_en = 1'b0;
    for (int k = 0; k < 2; k++) begin
      q0 = req_cyc; a0 = acc_cnt;
      send_pkt({(k == 0) ? 3'd3 : 3'd1, 1'b0, 4'(ID)}, 16'h1234, 32'h0BADF00D);
      get_reply(r);
      check(r[31:0] == 32'hDEADD0D0, "R10 timeout fault word", r[31:0], 32'hDEADD0D0);
      check(req_cyc - q0 == ACK, "R10 request length on timeout", 32'(req_cyc - q0), ACK);
      check(acc_cnt == a0, "R10 no access completed", 32'(acc_cnt - a0), 0);
    end
    ack_en = 1'b1;

    // R12: reply stalls long, then next command accepted
    ack_delay = 0;
    send_pkt({3'd0, 1'b0, 4'(ID)}, 16'h0, 32'h0);
    repeat (40) @(negedge clk);
    check(tx_valid && tx_data == (8'h10 | 8'(ID)) && !rx_ready, "R12 held reply byte",
          {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, 8'h10 | 8'(ID)});
    get_reply(r);
    check(r[31:0] == 32'hA110A110, "R6 R12 stalled reply", r[31:0], 32'hA110A110);

    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

endmodule